// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two operands and a single carry-in, and returns the sum and the carry-out. It has no clock, no state and no reset, so its outputs follow its inputs after the combinational delay of three stages.

The first stage forms a propagate/generate pair for every bit. The carry-in is folded into bit 0 in that stage, so the prefix at position 0 already spans from bit 0 down through the carry-in. The second stage is a divide-and-conquer prefix tree. At each of its log2(WIDTH) levels, every position in the upper half of a block joins with the top prefix of the lower half. A cell whose span reaches the carry-in yields a group generate only. Every other cell yields both the group propagate and the group generate. The third stage XORs each bit's propagate with the prefix carry from the bit below it.

The tree is built from explicit cell instances, so its topology can be read from the source. WIDTH must be a power of two.

Top module: `ppa_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i` for any operand values.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`, the carry out of the most significant bit.
- R3: A carry-in must travel the full width. With `a_i` all ones, `b_i` zero and `cin_i` = 1, the result is `sum_o` = 0 with `cout_o` = 1. With `a_i` all ones, `b_i` = 1 and `cin_i` = 0, the result is the same.
- R4: With both operands zero, `sum_o` equals `cin_i` in bit 0 with every other bit 0, and `cout_o` is 0.
- R5: When every bit propagates (`a_i ^ b_i` all ones, `a_i & b_i` zero), `cout_o` equals `cin_i`. `sum_o` is all ones for `cin_i` = 0 and zero for `cin_i` = 1.
- R6: A generate at bit k (`a_i` = `b_i` = 1 << k, `cin_i` = 0) sets only sum bit k+1. For k = WIDTH-1 it sets `cout_o` instead and leaves `sum_o` zero.
- R7: Swapping `a_i` and `b_i` leaves both `sum_o` and `cout_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The block holds no state, so a wrong internal value is a wrong prefix node, and it shows at the ports in the same evaluation as the inputs that select it. A bad combine cell at level k damages only the sum bits whose prefix passes through that node. The vectors are chosen so that each level's cells lie on some carry path: the full-width ripple cases, single generates walked across every bit, and all-propagate words. A wrong reduced cell near the carry-in position shows up as a wrong `cout_o` or a wrong low sum bit whenever `cin_i` toggles.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  // default operand width of the adder
  localparam int unsigned PPA_WIDTH = 32;

  // propagate / generate pair carried on a full (two-signal) tree wire
  typedef struct packed {
    logic p;
    logic g;
  } pg_t;
endpackage

// File: rtl/ppa_black_cell.sv
// Full combine cell: joins an upper group with the adjacent lower group and
// yields both group propagate and group generate.
module ppa_black_cell
  import ppa_pkg::*;
(
  input  pg_t hi_i,
  input  pg_t lo_i,
  output pg_t grp_o
);
  assign grp_o.g = hi_i.g | (hi_i.p & lo_i.g);
  assign grp_o.p = hi_i.p & lo_i.p;
endmodule

// File: rtl/ppa_gray_cell.sv
// Reduced combine cell: used once the lower group reaches the carry-in,
// so only the group generate (the carry) is needed.
module ppa_gray_cell
  import ppa_pkg::*;
(
  input  pg_t  hi_i,
  input  logic lo_g_i,
  output logic g_o
);
  assign g_o = hi_i.g | (hi_i.p & lo_g_i);
endmodule

// File: rtl/ppa_pg_stage.sv
// Bitwise propagate/generate stage. The carry-in is absorbed into position 0
// through a reduced cell, so node 0 already spans down to the carry-in.
module ppa_pg_stage
  import ppa_pkg::*;
#(
  parameter int unsigned WIDTH = PPA_WIDTH
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] p_o,
  output pg_t  [WIDTH-1:0] node_o
);
  logic [WIDTH-1:0] gen_bit;
  logic             g0_with_cin;

  assign p_o     = a_i ^ b_i;
  assign gen_bit = a_i & b_i;

  ppa_gray_cell u_cin_cell (
    .hi_i   ('{p: p_o[0], g: gen_bit[0]}),
    .lo_g_i (cin_i),
    .g_o    (g0_with_cin)
  );

  assign node_o[0] = '{p: 1'b0, g: g0_with_cin};

  for (genvar i = 1; i < WIDTH; i++) begin : g_node
    assign node_o[i] = '{p: p_o[i], g: gen_bit[i]};
  end
endmodule

// File: rtl/ppa_sklansky_tree.sv
// Divide-and-conquer prefix tree. At level lv, each position whose bit lv is
// set joins with the top position of the lower half of its 2^(lv+1) block.
module ppa_sklansky_tree
  import ppa_pkg::*;
#(
  parameter int unsigned WIDTH = PPA_WIDTH
) (
  input  pg_t  [WIDTH-1:0] node_i,
  output logic [WIDTH-1:0] carry_o
);
  localparam int unsigned LEVELS = $clog2(WIDTH);

  pg_t [WIDTH-1:0] lvl [LEVELS+1];

  assign lvl[0] = node_i;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    for (genvar i = 0; i < WIDTH; i++) begin : g_pos
      localparam int unsigned BLK  = 1 << (lv + 1);
      localparam int unsigned HALF = 1 << lv;
      localparam int unsigned SRC  = (i / BLK) * BLK + HALF - 1;
      if (((i >> lv) & 1) == 0) begin : g_pass
        // plain wire; a buffer here would carry no logic
        assign lvl[lv+1][i] = lvl[lv][i];
      end else if (i < BLK) begin : g_reduced
        // lower group reaches the carry-in: generate only
        logic carry_w;
        ppa_gray_cell u_cell (
          .hi_i   (lvl[lv][i]),
          .lo_g_i (lvl[lv][SRC].g),
          .g_o    (carry_w)
        );
        assign lvl[lv+1][i] = '{p: 1'b0, g: carry_w};
      end else begin : g_full
        ppa_black_cell u_cell (
          .hi_i  (lvl[lv][i]),
          .lo_i  (lvl[lv][SRC]),
          .grp_o (lvl[lv+1][i])
        );
      end
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign carry_o[i] = lvl[LEVELS][i].g;
  end

  // a local generate must always produce a carry out of that position
  always_comb begin
    for (int k = 0; k < int'(WIDTH); k++) begin
      if (node_i[k].g) begin
        AST_GEN_SETS_CARRY: assert (carry_o[k]); // R6
      end
    end
  end
endmodule

// File: rtl/ppa_sum_stage.sv
// Sum XOR stage: each bit XORs its propagate with the carry from below.
module ppa_sum_stage
  import ppa_pkg::*;
#(
  parameter int unsigned WIDTH = PPA_WIDTH
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] carry_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  assign sum_o  = p_i ^ {carry_i[WIDTH-2:0], cin_i};
  assign cout_o = carry_i[WIDTH-1];
endmodule

// File: rtl/ppa_adder.sv
module ppa_adder
  import ppa_pkg::*;
#(
  parameter int unsigned WIDTH = PPA_WIDTH
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] prop;
  pg_t  [WIDTH-1:0] node;
  logic [WIDTH-1:0] carry;

  ppa_pg_stage #(.WIDTH(WIDTH)) u_pg (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .p_o    (prop),
    .node_o (node)
  );

  ppa_sklansky_tree #(.WIDTH(WIDTH)) u_tree (
    .node_i  (node),
    .carry_o (carry)
  );

  ppa_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .p_i     (prop),
    .carry_i (carry),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o)
  );

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    AST_SUM_BITS: assert (sum_o == ref_total[WIDTH-1:0]); // R1
    AST_CARRY_OUT: assert (cout_o == ref_total[WIDTH]); // R2
    if (&a_i && b_i == '0 && cin_i) begin
      AST_FULL_RIPPLE: assert (sum_o == '0 && cout_o); // R3
    end
    if (a_i == '0 && b_i == '0) begin
      AST_ZERO_OPERANDS: assert (sum_o == {{(WIDTH-1){1'b0}}, cin_i} && !cout_o); // R4
    end
    if (&(a_i ^ b_i)) begin
      AST_ALL_PROPAGATE: assert (cout_o == cin_i); // R5
    end
  end
endmodule

// File: tb/ppa_adder_tb_top.sv
module ppa_adder_tb_top;
  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic [W-1:0] s;
    logic         co;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0}, // R4
    '{32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0001, 1'b0}, // R4
    '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1}, // R3
    '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1}, // R3
    '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 32'hFFFF_FFFF, 1'b0}, // R5
    '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b1}, // R5
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1}, // R1 R2
    '{32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R6
    '{32'h0000_8000, 32'h0000_8000, 1'b0, 32'h0001_0000, 1'b0}, // R6
    '{32'h1234_5678, 32'h8765_4321, 1'b0, 32'h9999_9999, 1'b0}, // R1
    '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0}, // R1
    '{32'h0000_FFFF, 32'h0000_FFFF, 1'b1, 32'h0001_FFFF, 1'b0}  // R1 R2
  };

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int           n_checks;
  int           n_fail;
  bit           done;

  ppa_adder #(.WIDTH(W)) dut_i (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    @(posedge clk);
    a   = va;
    b   = vb;
    cin = vc;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [W-1:0] es, input logic ec);
    n_checks++;
    if (sum !== es || cout !== ec) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%0b got sum=%h cout=%0b expected sum=%h cout=%0b",
               tag, a, b, cin, sum, cout, es, ec);
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 power-up zero", '0, 1'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].cin);
      check($sformatf("table row %0d (R1..R6 per row)", i), VECS[i].s, VECS[i].co);
    end

    // R6: single generate walked over every bit
    for (int k = 0; k < W; k++) begin
      logic [W:0] ex;
      ex = (W+1)'(1) << (k + 1);
      apply(W'(1) << k, W'(1) << k, 1'b0);
      check($sformatf("R6 generate at bit %0d", k), ex[W-1:0], ex[W]);
    end

    // R3: carry-in ripples past a run of ones of every length
    for (int k = 1; k <= W; k++) begin
      logic [W:0] ex;
      logic [W-1:0] run;
      run = (k == W) ? '1 : ((W'(1) << k) - 1);
      ex  = (W+1)'(1) << k;
      apply(run, '0, 1'b1);
      check($sformatf("R3 ripple over %0d ones", k), ex[W-1:0], ex[W]);
    end

    // R5: all-propagate words of several shapes, both carry-in values
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] m;
      m = $urandom();
      apply(m, ~m, 1'b0);
      check("R5 all-propagate cin=0", '1, 1'b0);
      apply(m, ~m, 1'b1);
      check("R5 all-propagate cin=1", '0, 1'b1);
    end

    // R1, R2, R7: random operands, then swapped
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] ra, rb;
      logic         rc;
      logic [W:0]   ex;
      ra = $urandom();
      rb = $urandom();
      rc = 1'($urandom());
      ex = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc};
      apply(ra, rb, rc);
      check("R1 R2 random", ex[W-1:0], ex[W]);
      apply(rb, ra, rc);
      check("R7 swapped operands", ex[W-1:0], ex[W]);
    end

    // R4: back to zero operands after nonzero history
    apply('0, '0, 1'b1);
    check("R4 zero operands cin=1", 32'h1, 1'b0);
    apply('0, '0, 1'b0);
    check("R4 zero operands cin=0", '0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule